// File: doc/BRIEF.md
# Multi-format audio serial port

This block carries stereo PCM samples over a three-wire serial audio link made of a bit clock, a frame clock and one data line per direction. The record direction takes a parallel left/right pair and shifts it out; the playback direction shifts serial data in and presents the left and right words in parallel, with a one-cycle strobe once a whole frame has arrived. A 2-bit format field picks one of four framings, and a word-length field sets the sample size anywhere from 16 to 32 bits. Every framing sends the most significant bit first.

The link clocks come from an external clock source and are never used as clocks here. The bit clock, the frame clock and the serial input are passed through synchronizers and oversampled by the faster system clock. Edges are found by comparing samples, so the whole block runs in one clock domain. Incoming bits are captured on bit-clock rising edges, and the outgoing line is updated while the bit clock is low. A slot counter, restarted at each frame-clock edge, gives every bit clock its place in the word.

Top module: `audio_serial_port`

## Requirements
- R1: With format code 01 (left-justified), the left word is carried while the frame clock is high and its MSB sits in the first bit-clock slot after the frame-clock edge; the right word follows the same rule while the frame clock is low.
- R2: With format code 10 (I2S), the left word is carried while the frame clock is low, and each word's MSB sits one bit-clock slot after the frame-clock edge.
- R3: With format code 00 (right-justified), the left word is carried while the frame clock is high and each word's LSB sits in the last slot before the next frame-clock edge; the half-frame length is taken from the preceding half-frame.
- R4: With format code 11 (DSP), a frame begins with a frame-clock pulse that is high for one slot; the left MSB sits in the slot after the pulse, and the right MSB sits in the slot right after the left LSB.
- R5: The word length W is set by the word-length input (16 to 32) and bits travel MSB first; received words are right-aligned, with every bit at position W and above reading zero, and transmit words use bits W-1 to 0 of the parallel inputs.
- R6: Bits on the serial input in slots outside the two words of a frame have no effect on the received words.
- R7: The playback valid strobe is high for exactly one system clock cycle per frame, after the right word's LSB has been captured, and only if the left word of the same frame was captured; both received words hold their values between strobes.
- R8: The record pair is loaded at each frame-start edge (rising frame clock for codes 00, 01 and 11; falling for code 10), marked by a one-cycle load strobe; the serial output carries the pair in the same slot positions as the receive side and is zero in all other slots.
- R9: The serial output changes only while the synchronized bit clock is low, so it is stable across every bit-clock high phase.
- R10: After reset, all outputs are zero, and no word is captured and no strobe raised until a frame-clock edge has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least ten times the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Framing: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP |
| wlen_i | input | 6 | Word length in bits, 16 to 32 |
| bclk_i | input | 1 | Serial bit clock from the link |
| lrclk_i | input | 1 | Serial frame clock from the link |
| play_sd_i | input | 1 | Playback serial data in |
| rec_left_i | input | 32 | Left sample to transmit, right-aligned |
| rec_right_i | input | 32 | Right sample to transmit, right-aligned |
| rec_sd_o | output | 1 | Record serial data out |
| rec_load_o | output | 1 | One-cycle strobe: record pair taken at frame start |
| play_left_o | output | 32 | Last received left word, right-aligned |
| play_right_o | output | 32 | Last received right word, right-aligned |
| play_valid_o | output | 1 | One-cycle strobe: a new stereo pair is present |

## Verification
A pin change reaches the logic two system cycles later, through the synchronizers. The load strobe therefore appears two cycles after a frame-clock edge, the new output bit three to four cycles after a bit-clock fall, and the valid strobe with its words one cycle after the right LSB's rising edge is seen. The bench holds each bit-clock phase for six system cycles. It samples the serial output just before it raises the bit clock, samples it again at the end of the high phase, and checks the received words and strobe counts only after the whole frame has been driven, well past every latency.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } asp_fmt_e;

endpackage

// File: rtl/asp_pin_sync.sv
module asp_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din_i,
    output logic [N-1:0] dout_o
);

    logic [STAGES-1:0][N-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout_o = stg_q[STAGES-1];

endmodule

// File: rtl/asp_slot_tracker.sv
module asp_slot_tracker
    import asp_pkg::*;
#(
    parameter int DW  = 32,
    parameter int PW  = 9,
    parameter int WLW = $clog2(DW + 1),
    parameter int IW  = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  asp_fmt_e       fmt_i,
    input  logic [WLW-1:0] wlen_i,
    input  logic           bclk_s_i,
    input  logic           lr_s_i,
    output logic           rise_o,
    output logic           frame_start_o,
    output logic           act_o,
    output logic           left_o,
    output logic           first_o,
    output logic           last_o,
    output logic [IW-1:0]  idx_o
);

    localparam int SW = PW + 2;

    typedef struct packed {
        logic          bclk_p;
        logic          lr_p;
        logic          lr_last;
        logic [PW-1:0] pos;
        logic [PW-1:0] half_len;
    } trk_t;

    trk_t st_d, st_q;

    logic                 dsp, start_now, pos_sat;
    logic [PW-1:0]        slot_pos;
    logic signed [SW-1:0] wl_s, off_s, k_s, kk_s;

    always_comb begin
        st_d      = st_q;
        dsp       = (fmt_i == FMT_DSP);
        start_now = dsp ? (lr_s_i & ~st_q.lr_last) : (lr_s_i ^ st_q.lr_last);
        pos_sat   = &st_q.pos;

        if (start_now)    slot_pos = '0;
        else if (pos_sat) slot_pos = st_q.pos;
        else              slot_pos = st_q.pos + 1'b1;

        wl_s = signed'(SW'(wlen_i));
        case (fmt_i)
            FMT_RJ:  off_s = signed'(SW'(st_q.half_len)) - wl_s;
            FMT_LJ:  off_s = '0;
            default: off_s = SW'(1);
        endcase
        k_s = signed'(SW'(slot_pos)) - off_s;

        if (dsp) begin
            act_o  = (k_s >= 0) && (k_s < (wl_s <<< 1));
            left_o = (k_s < wl_s);
            kk_s   = left_o ? k_s : (k_s - wl_s);
        end else begin
            act_o  = (k_s >= 0) && (k_s < wl_s);
            left_o = (fmt_i == FMT_I2S) ? ~lr_s_i : lr_s_i;
            kk_s   = k_s;
        end
        first_o = (kk_s == 0);
        last_o  = (kk_s == wl_s - 1);
        idx_o   = IW'(wl_s - 1 - kk_s);

        rise_o        = bclk_s_i & ~st_q.bclk_p;
        frame_start_o = (fmt_i == FMT_I2S) ? (~lr_s_i & st_q.lr_p)
                                           : (lr_s_i & ~st_q.lr_p);

        st_d.bclk_p = bclk_s_i;
        st_d.lr_p   = lr_s_i;
        if (rise_o) begin
            st_d.pos     = slot_pos;
            st_d.lr_last = lr_s_i;
            if (start_now && !dsp) begin
                st_d.half_len = pos_sat ? '0 : st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          act_i,
    input  logic          left_i,
    input  logic          first_i,
    input  logic          last_i,
    input  logic          sd_i,
    output logic [DW-1:0] left_o,
    output logic [DW-1:0] right_o,
    output logic          valid_o
);

    typedef struct packed {
        logic [DW-1:0] sh_l;
        logic [DW-1:0] sh_r;
        logic [DW-1:0] out_l;
        logic [DW-1:0] out_r;
        logic          got_l;
        logic          valid;
    } rx_t;

    rx_t st_d, st_q;
    logic [DW-1:0] nxt_l, nxt_r;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        nxt_l = first_i ? {{(DW-1){1'b0}}, sd_i} : {st_q.sh_l[DW-2:0], sd_i};
        nxt_r = first_i ? {{(DW-1){1'b0}}, sd_i} : {st_q.sh_r[DW-2:0], sd_i};
        if (rise_i && act_i) begin
            if (left_i) begin
                st_d.sh_l = nxt_l;
                if (first_i) st_d.got_l = 1'b0;
                if (last_i)  st_d.got_l = 1'b1;
            end else begin
                st_d.sh_r = nxt_r;
                if (last_i) begin
                    if (st_q.got_l) begin
                        st_d.out_l = st_q.sh_l;
                        st_d.out_r = nxt_r;
                        st_d.valid = 1'b1;
                    end
                    st_d.got_l = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.out_l;
    assign right_o = st_q.out_r;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
    parameter int DW = 32,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] left_i,
    input  logic [DW-1:0] right_i,
    input  logic          bclk_hi_i,
    input  logic          act_i,
    input  logic          sel_left_i,
    input  logic [IW-1:0] idx_i,
    output logic          sd_o
);

    typedef struct packed {
        logic [DW-1:0] word_l;
        logic [DW-1:0] word_r;
        logic          sd;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word_l = left_i;
            st_d.word_r = right_i;
        end
        if (!bclk_hi_i) begin
            if (act_i) st_d.sd = sel_left_i ? st_q.word_l[idx_i] : st_q.word_r[idx_i];
            else       st_d.sd = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sd_o = st_q.sd;

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int DW          = 32,
    parameter int PW          = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               fmt_i,
    input  logic [$clog2(DW+1)-1:0]  wlen_i,
    input  logic                     bclk_i,
    input  logic                     lrclk_i,
    input  logic                     play_sd_i,
    input  logic [DW-1:0]            rec_left_i,
    input  logic [DW-1:0]            rec_right_i,
    output logic                     rec_sd_o,
    output logic                     rec_load_o,
    output logic [DW-1:0]            play_left_o,
    output logic [DW-1:0]            play_right_o,
    output logic                     play_valid_o
);

    localparam int WLW = $clog2(DW + 1);
    localparam int IW  = $clog2(DW);

    asp_fmt_e      fmt;
    logic [2:0]    pins_s;
    logic          bclk_s, lr_s, sd_s;
    logic          rise, fstart, act, sel_left, first, last;
    logic [IW-1:0] idx;

    assign fmt = asp_fmt_e'(fmt_i);

    asp_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({bclk_i, lrclk_i, play_sd_i}),
        .dout_o (pins_s)
    );
    assign {bclk_s, lr_s, sd_s} = pins_s;

    asp_slot_tracker #(.DW(DW), .PW(PW), .WLW(WLW), .IW(IW)) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .fmt_i         (fmt),
        .wlen_i        (wlen_i),
        .bclk_s_i      (bclk_s),
        .lr_s_i        (lr_s),
        .rise_o        (rise),
        .frame_start_o (fstart),
        .act_o         (act),
        .left_o        (sel_left),
        .first_o       (first),
        .last_o        (last),
        .idx_o         (idx)
    );

    asp_rx #(.DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .act_i   (act),
        .left_i  (sel_left),
        .first_i (first),
        .last_i  (last),
        .sd_i    (sd_s),
        .left_o  (play_left_o),
        .right_o (play_right_o),
        .valid_o (play_valid_o)
    );

    asp_tx #(.DW(DW), .IW(IW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (fstart),
        .left_i     (rec_left_i),
        .right_i    (rec_right_i),
        .bclk_hi_i  (bclk_s),
        .act_i      (act),
        .sel_left_i (sel_left),
        .idx_i      (idx),
        .sd_o       (rec_sd_o)
    );

    assign rec_load_o = fstart;

endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
    parameter int DW  = 32,
    parameter int WLW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [WLW-1:0] wlen,
    input logic           bclk_hi,
    input logic           rec_sd,
    input logic           rec_load,
    input logic [DW-1:0]  play_left,
    input logic [DW-1:0]  play_right,
    input logic           play_valid
);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        play_valid |=> !play_valid); // R7

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !play_valid |-> ($stable(play_left) && $stable(play_right))); // R7

    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        play_valid |-> (((64'(play_left) >> wlen) == 64'd0) &&
                        ((64'(play_right) >> wlen) == 64'd0))); // R5

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_load |=> !rec_load); // R8

    AST_SD_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bclk_hi) |-> $stable(rec_sd)); // R9

endmodule

bind audio_serial_port asp_checker #(.DW(DW), .WLW(WLW)) u_asp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wlen       (wlen_i),
    .bclk_hi    (bclk_s),
    .rec_sd     (rec_sd_o),
    .rec_load   (rec_load_o),
    .play_left  (play_left_o),
    .play_right (play_right_o),
    .play_valid (play_valid_o)
);

// File: tb/test_audio_serial_port.sv
module test_audio_serial_port;

    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_i = 2'b01;
    logic [5:0]  wlen_i = 6'd16;
    logic        bclk_i = 1'b0, lrclk_i = 1'b0, play_sd_i = 1'b0;
    logic [31:0] rec_left_i = '0, rec_right_i = '0;
    logic        rec_sd_o, rec_load_o, play_valid_o;
    logic [31:0] play_left_o, play_right_o;

    int checks = 0, fails = 0, vcnt = 0, lcnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    audio_serial_port i_audio_serial_port (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .wlen_i(wlen_i),
        .bclk_i(bclk_i), .lrclk_i(lrclk_i), .play_sd_i(play_sd_i),
        .rec_left_i(rec_left_i), .rec_right_i(rec_right_i),
        .rec_sd_o(rec_sd_o), .rec_load_o(rec_load_o),
        .play_left_o(play_left_o), .play_right_o(play_right_o),
        .play_valid_o(play_valid_o)
    );

    always @(posedge clk) begin
        if (rst_n && play_valid_o) vcnt <= vcnt + 1;
        if (rst_n && rec_load_o)   lcnt <= lcnt + 1;
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic string fmt_tag(input int f);
        case (f)
            0: return "R3";
            1: return "R1";
            2: return "R2";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [31:0] wmask(input int w);
        logic [63:0] m = (64'd1 << w) - 64'd1;
        return m[31:0];
    endfunction

    function automatic bit slot_lr(input int f, input int s, input int S);
        case (f)
            0, 1: return s < S;
            2: return s >= S;
            default: return s == 0;
        endcase
    endfunction

    // -1: no data; 64+idx: left bit idx; idx: right bit idx
    function automatic int slot_map(input int f, input int W, input int S, input int s);
        case (f)
            0: begin
                if (s >= S - W && s < S) return 64 + (S - 1 - s);
                if (s >= 2*S - W)        return 2*S - 1 - s;
            end
            1: begin
                if (s < W)                 return 64 + W - 1 - s;
                if (s >= S && s < S + W)   return W - 1 - (s - S);
            end
            2: begin
                if (s >= 1 && s <= W)         return 64 + W - s;
                if (s >= S + 1 && s <= S + W) return W - (s - S);
            end
            default: begin
                if (s >= 1 && s <= W)       return 64 + W - s;
                if (s >= W + 1 && s <= 2*W) return 2*W - s;
            end
        endcase
        return -1;
    endfunction

    task automatic do_slot(input bit lrv, input bit sdv, output bit cap, output bit steady);
        bclk_i = 1'b0; lrclk_i = lrv; play_sd_i = sdv;
        repeat (H) @(posedge clk);
        #1;
        cap = rec_sd_o;
        bclk_i = 1'b1;
        repeat (H) @(posedge clk);
        #1;
        steady = (rec_sd_o == cap);
    endtask

    task automatic run_frame(input int f, input int W, input int S, input bit check);
        logic [31:0] L = $urandom, R = $urandom, capl = '0, capr = '0, m32;
        bit idle_bad = 0, hold_bad = 0, cap, steady, sdv;
        int vc0 = vcnt, lc0 = lcnt;
        string t = fmt_tag(f);
        rec_left_i = $urandom; rec_right_i = $urandom;
        m32 = wmask(W);
        for (int s = 0; s < 2*S; s++) begin
            int m = slot_map(f, W, S, s);
            if (m < 0)       sdv = 1'($urandom % 2);
            else if (m >= 64) sdv = L[m-64];
            else              sdv = R[m];
            do_slot(slot_lr(f, s, S), sdv, cap, steady);
            if (m < 0)        idle_bad |= cap;
            else if (m >= 64) capl[m-64] = cap;
            else              capr[m] = cap;
            hold_bad |= !steady;
        end
        if (check) begin
            chk(vcnt == vc0 + 1, {t, " R7 one valid per frame"}, 64'(vcnt - vc0), 64'd1);
            chk(play_left_o == (L & m32), {t, " R5 R6 rx left"}, 64'(play_left_o), 64'(L & m32));
            chk(play_right_o == (R & m32), {t, " R5 R6 rx right"}, 64'(play_right_o), 64'(R & m32));
            chk(capl == (rec_left_i & m32), {t, " R8 tx left"}, 64'(capl), 64'(rec_left_i & m32));
            chk(capr == (rec_right_i & m32), {t, " R8 tx right"}, 64'(capr), 64'(rec_right_i & m32));
            chk(!idle_bad, "R8 tx zero outside words", 64'(idle_bad), 64'd0);
            chk(lcnt == lc0 + 1, "R8 one load per frame", 64'(lcnt - lc0), 64'd1);
            chk(!hold_bad, "R9 tx stable in high phase", 64'(hold_bad), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit cap, steady;
        void'($urandom(32'h5eed_0a17));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R10: reset state
        chk(play_valid_o == 0 && play_left_o == 0 && play_right_o == 0,
            "R10 rx outputs after reset", 64'(play_left_o), 64'd0);
        chk(rec_sd_o == 0 && rec_load_o == 0, "R10 tx outputs after reset", 64'(rec_sd_o), 64'd0);
        // R10: bit clock running, no frame-clock edge yet
        for (int s = 0; s < 40; s++) do_slot(1'b0, 1'($urandom % 2), cap, steady);
        chk(vcnt == 0, "R10 no valid before frame edge", 64'(vcnt), 64'd0);
        chk(lcnt == 0 && rec_sd_o == 0, "R10 no load before frame edge", 64'(lcnt), 64'd0);

        for (int f = 0; f < 4; f++) begin
            for (int wi = 0; wi < 3; wi++) begin
                int W = (wi == 0) ? 16 : (wi == 1) ? 32 : 17 + int'($urandom % 15);
                int S = (wi == 1) ? W + 1 : W + 1 + int'($urandom % 8);
                fmt_i = 2'(f); wlen_i = 6'(W);
                run_frame(f, W, S, 1'b0);
                run_frame(f, W, S, 1'b0);
                for (int n = 0; n < 3; n++) run_frame(f, W, S, 1'b1);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule